// File: doc/BRIEF.md
# Clocked-Serial Slave Transceiver Channel

This block is one full-duplex serial channel that works only as a slave. A remote master drives the serial clock. On each frame the block shifts a word out on its data output and shifts a word in from its data input at the same time. The serial clock and the data input are not used as clocks. The block samples both with its own operation clock through a synchroniser and then finds the clock edges by comparing successive samples. Because of this oversampling, each level of the serial clock must last at least three operation-clock cycles, so the serial clock can run at no more than one sixth of the operation clock.

On the host side there are a few pieces:
- A transmit holding register, written by a one-cycle strobe.
- A receive register, acknowledged by a one-cycle read strobe.
- Static configuration inputs: clock polarity, data phase, 7- or 8-bit frames, bit order, and single or continuous mode.
- One interrupt pulse.
- A sticky overrun flag with its own clear strobe.

In single mode the interrupt marks the end of a frame. In continuous mode it fires when the holding register is copied into the shifter at the start of a frame, so the host can queue the next word early.

Top module: `sio_slave_chan`

## Requirements
- R1: After reset `sdo_o`, `irq_o`, `ovr_o` and `rx_data` are all 0.
- R2: Let k be `sclk_i` XOR `cfg_cpol`. When idle, k is 1. With `cfg_dphase`=0 the output changes on falling edges of k and the input is captured on rising edges of k. With `cfg_dphase`=1 these two roles swap. Each level of `sclk_i` is held for at least 3 clock cycles.
- R3: `cfg_len7`=1 selects 7-bit frames, which use word bits 6..0, and bit 7 of `rx_data` reads 0. `cfg_len7`=0 selects 8-bit frames.
- R4: `cfg_lsb_first`=0 sends and receives the highest used bit first. `cfg_lsb_first`=1 puts bit 0 first.
- R5: With `cfg_dphase`=0 the first bit of the loaded word appears on `sdo_o` after the first falling edge of k. With `cfg_dphase`=1 that bit is already on `sdo_o` while the clock is idle, before the first edge.
- R6: After the last capture edge of a frame, `rx_data` holds the word received on `sdi_i`. This happens in the same frame as the transmission.
- R7: With `cfg_cont`=0, `irq_o` gives one pulse of one clock cycle when a frame completes, and no pulse during the frame.
- R8: With `cfg_cont`=1, `irq_o` gives one pulse of one clock cycle when the holding register is copied into the shifter at the start of a frame, and no pulse at frame end.
- R9: If a frame completes while the previous received word has not been read with `rx_rd`, `ovr_o` is set and `rx_data` takes the newer word. `ovr_o` then stays 1 until `ovr_clr` is pulsed.
- R10: If `tx_wr` has not been pulsed since the last frame, the next frame sends the last written word again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the remote master |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| cfg_cpol | input | 1 | 1 inverts the serial clock |
| cfg_dphase | input | 1 | 1 presents the first bit half a period early |
| cfg_len7 | input | 1 | 1 selects 7-bit frames |
| cfg_lsb_first | input | 1 | 1 selects bit 0 first |
| cfg_cont | input | 1 | 1 selects continuous mode |
| tx_wr | input | 1 | Strobe that writes the transmit holding register |
| tx_data | input | DATA_W | Transmit word |
| rx_rd | input | 1 | Strobe that acknowledges the received word |
| rx_data | output | DATA_W | Last received word |
| ovr_clr | input | 1 | Strobe that clears the overrun flag |
| irq_o | output | 1 | Interrupt pulse (frame end or buffer empty) |
| ovr_o | output | 1 | Sticky receive overrun flag |

## Verification
The hardest states to reach are an overrun and a repeated transmit word. Both need several complete frames in a row with the host staying passive: no read strobe and no transmit write in between. The stimulus runs two full frames back to back without touching `rx_rd` or `tx_wr`. It then watches `ovr_o` through an idle gap before clearing it. The early first bit of the data-phase option is observed by sampling `sdo_o` while the serial clock is still idle. The timing of the interrupt is told apart by counting pulses once after the first bit and again after the frame.

// File: rtl/sio_slave_pkg.sv
package sio_slave_pkg;

  // Idle level of the polarity-corrected serial clock
  localparam logic K_IDLE = 1'b1;

  typedef struct packed {
    logic cpol;
    logic dphase;
    logic len7;
    logic lsb_first;
    logic cont;
  } sio_cfg_t;

endpackage

// File: rtl/sio_edge_sync.sv
module sio_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sdi_i,
  input  logic cpol,
  output logic k_rise,
  output logic k_fall,
  output logic sdi_s
);
  import sio_slave_pkg::*;

  localparam int KW = SYNC_STAGES + 1;

  logic [KW-1:0]          k_q, k_n;
  logic [SYNC_STAGES-1:0] d_q, d_n;

  // Polarity is applied before the synchroniser so a polarity change that
  // coincides with the matching pin change produces no internal edge.
  always_comb begin
    k_n = {k_q[KW-2:0], sclk_i ^ cpol};
    d_n = {d_q[SYNC_STAGES-2:0], sdi_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q <= {KW{K_IDLE}};
      d_q <= '0;
    end else begin
      k_q <= k_n;
      d_q <= d_n;
    end
  end

  assign k_rise = ~k_q[KW-1] &  k_q[KW-2];
  assign k_fall =  k_q[KW-1] & ~k_q[KW-2];
  assign sdi_s  =  d_q[SYNC_STAGES-1];

endmodule

// File: rtl/sio_shift_core.sv
module sio_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drv_edge,
  input  logic              smp_edge,
  input  logic              sdi_s,
  input  logic              dphase,
  input  logic              len7,
  input  logic              lsb_first,
  input  logic [DATA_W-1:0] tx_word,
  output logic              sdo,
  output logic              frame_start,
  output logic              frame_done,
  output logic [DATA_W-1:0] rx_word
);

  localparam int CNT_W = $clog2(DATA_W);

  logic [CNT_W-1:0]  scnt, scnt_n;   // bits captured in this frame
  logic [CNT_W-1:0]  oidx, oidx_n;   // index of the bit on the output
  logic [DATA_W-1:0] txw, txw_n;
  logic [DATA_W-1:0] rxa, rx_next;
  logic [CNT_W-1:0]  last_idx, opos, spos, first_pos;
  logic              idle;

  assign last_idx  = len7 ? CNT_W'(DATA_W - 2) : CNT_W'(DATA_W - 1);
  assign opos      = lsb_first ? oidx : last_idx - oidx;
  assign spos      = lsb_first ? scnt : last_idx - scnt;
  assign first_pos = lsb_first ? '0 : last_idx;
  assign idle      = (scnt == '0);

  assign frame_start = idle & (dphase ? smp_edge : drv_edge);
  assign frame_done  = smp_edge & (scnt == last_idx);

  always_comb begin
    txw_n  = txw;
    oidx_n = oidx;
    if (frame_start) begin
      txw_n  = tx_word;
      oidx_n = '0;
    end else if (drv_edge && !idle) begin
      oidx_n = oidx + 1'b1;
    end
  end

  always_comb begin
    rx_next       = idle ? '0 : rxa;
    rx_next[spos] = sdi_s;
  end

  always_comb begin
    scnt_n = scnt;
    if (smp_edge) scnt_n = (scnt == last_idx) ? '0 : scnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt <= '0;
      oidx <= '0;
      txw  <= '0;
      rxa  <= '0;
    end else begin
      scnt <= scnt_n;
      oidx <= oidx_n;
      txw  <= txw_n;
      if (smp_edge) rxa <= rx_next;
    end
  end

  // Early-phase mode shows the holding word's first bit while idle
  assign sdo     = (dphase && idle) ? tx_word[first_pos] : txw[opos];
  assign rx_word = rx_next;

  assert_count_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scnt <= last_idx);

  assert_done_rewinds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> idle);

endmodule

// File: rtl/sio_slave_chan.sv
module sio_slave_chan #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic              cfg_cpol,
  input  logic              cfg_dphase,
  input  logic              cfg_len7,
  input  logic              cfg_lsb_first,
  input  logic              cfg_cont,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  input  logic              ovr_clr,
  output logic              irq_o,
  output logic              ovr_o
);
  import sio_slave_pkg::*;

  sio_cfg_t cfg;
  assign cfg = '{cpol: cfg_cpol, dphase: cfg_dphase, len7: cfg_len7,
                 lsb_first: cfg_lsb_first, cont: cfg_cont};

  logic k_rise, k_fall, sdi_s, drv_edge, smp_edge;
  logic frame_start, frame_done;
  logic [DATA_W-1:0] rx_word;

  logic [DATA_W-1:0] tx_buf, rx_buf, rx_buf_n;
  logic rx_full, rx_full_n, ovr_q, ovr_n, irq_q, irq_n;

  sio_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdi_i(sdi_i), .cpol(cfg.cpol),
    .k_rise(k_rise), .k_fall(k_fall), .sdi_s(sdi_s)
  );

  assign drv_edge = cfg.dphase ? k_rise : k_fall;
  assign smp_edge = cfg.dphase ? k_fall : k_rise;

  sio_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .drv_edge(drv_edge), .smp_edge(smp_edge),
    .sdi_s(sdi_s), .dphase(cfg.dphase), .len7(cfg.len7),
    .lsb_first(cfg.lsb_first), .tx_word(tx_buf), .sdo(sdo_o),
    .frame_start(frame_start), .frame_done(frame_done), .rx_word(rx_word)
  );

  always_comb begin
    rx_buf_n  = rx_buf;
    rx_full_n = rx_full;
    ovr_n     = ovr_q;
    if (rx_rd)   rx_full_n = 1'b0;
    if (ovr_clr) ovr_n     = 1'b0;
    if (frame_done) begin
      rx_buf_n  = rx_word;
      rx_full_n = 1'b1;
      if (rx_full && !rx_rd) ovr_n = 1'b1;
    end
    irq_n = cfg.cont ? frame_start : frame_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf  <= '0;
      rx_buf  <= '0;
      rx_full <= 1'b0;
      ovr_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (tx_wr) tx_buf <= tx_data;
      rx_buf  <= rx_buf_n;
      rx_full <= rx_full_n;
      ovr_q   <= ovr_n;
      irq_q   <= irq_n;
    end
  end

  assign rx_data = rx_buf;
  assign irq_o   = irq_q;
  assign ovr_o   = ovr_q;

  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_full && !rx_rd) |=> ovr_o);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_o && !ovr_clr) |=> ovr_o);

  assert_rx_loaded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (rx_data == $past(rx_word)));

  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_irq_single_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !cfg_cont) |-> $past(frame_done));

endmodule

// File: tb/test_sio_slave_chan.sv
module test_sio_slave_chan;

  localparam int H = 4;   // operation clocks per serial clock level
  // {cpol, dphase, len7, lsb_first, cont, tx[7:0], mosi[7:0]}
  localparam logic [20:0] VEC [6] = '{
    {5'b00000, 8'hA5, 8'h3C},
    {5'b10010, 8'h81, 8'h7E},
    {5'b01001, 8'hC3, 8'h55},
    {5'b11111, 8'h5A, 8'hAB},
    {5'b00101, 8'hFF, 8'h81},
    {5'b11000, 8'h12, 8'hED}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, sdi = 1'b0;
  logic cpol = 1'b0, dph = 1'b0, len7 = 1'b0, lsb = 1'b0, cont = 1'b0;
  logic tx_wr = 1'b0, rx_rd = 1'b0, ovr_clr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic sdo, irq, ovr;
  logic [7:0] rx_data;
  int n_chk = 0, n_fail = 0, irq_cnt = 0;

  always #10 clk = ~clk;

  sio_slave_chan i_sio_slave_chan (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo),
    .cfg_cpol(cpol), .cfg_dphase(dph), .cfg_len7(len7),
    .cfg_lsb_first(lsb), .cfg_cont(cont), .tx_wr(tx_wr), .tx_data(tx_data),
    .rx_rd(rx_rd), .rx_data(rx_data), .ovr_clr(ovr_clr), .irq_o(irq),
    .ovr_o(ovr)
  );

  always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; wait_clk(1); s = 1'b0;
  endtask

  task automatic set_cfg(input logic [4:0] c);
    {cpol, dph, len7, lsb, cont} = c;
    sclk = 1'b1 ^ c[4];
    wait_clk(6);
  endtask

  // Master side of one frame; miso assembled per R2, R4, R5
  task automatic xfer(input logic [7:0] mosi, output logic [7:0] miso,
                      output int irq_mid, output int irq_end);
    int n = len7 ? 7 : 8;
    int base = irq_cnt;
    miso = 8'h00;
    for (int i = 0; i < n; i++) begin
      int p = lsb ? i : n - 1 - i;
      if (!dph) begin
        sclk = 1'b0 ^ cpol; sdi = mosi[p]; wait_clk(H);
        miso[p] = sdo;
        sclk = 1'b1 ^ cpol; wait_clk(H);
      end else begin
        sdi = mosi[p]; wait_clk(H);
        miso[p] = sdo;
        sclk = 1'b0 ^ cpol; wait_clk(H);
        sclk = 1'b1 ^ cpol; wait_clk(H);
      end
      if (i == 0) irq_mid = irq_cnt - base;
    end
    wait_clk(4);
    irq_end = irq_cnt - base;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] miso, mask;
    int im, ie;
    wait_clk(3);
    // R1: reset state
    chk("R1 sdo", sdo, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ovr", ovr, 0);
    chk("R1 rx_data", rx_data, 0);
    rst_n = 1'b1;
    wait_clk(4);

    for (int v = 0; v < 6; v++) begin
      set_cfg(VEC[v][20:16]);
      tx_data = VEC[v][15:8];
      pulse(tx_wr);
      wait_clk(2);
      mask = len7 ? 8'h7F : 8'hFF;
      xfer(VEC[v][7:0], miso, im, ie);
      chk("R5 R4 R2 data out", miso, VEC[v][15:8] & mask);
      chk(len7 ? "R3 data in" : "R6 data in", rx_data, VEC[v][7:0] & mask);
      chk(cont ? "R8 irq at start" : "R7 irq during frame", im, cont ? 1 : 0);
      chk(cont ? "R8 irq count" : "R7 irq at end", ie, 1);
      pulse(rx_rd);
      wait_clk(2);
    end

    // R10 and R9: two frames without a write or a read
    set_cfg(5'b00000);
    xfer(8'h11, miso, im, ie);
    chk("R10 repeat first", miso, 8'h12);
    chk("R9 no overrun yet", ovr, 0);
    xfer(8'h22, miso, im, ie);
    chk("R10 repeat second", miso, 8'h12);
    chk("R9 overrun set", ovr, 1);
    chk("R9 newer word kept", rx_data, 8'h22);
    wait_clk(20);
    chk("R9 overrun sticky", ovr, 1);
    pulse(ovr_clr);
    wait_clk(1);
    chk("R9 overrun cleared", ovr, 0);
    pulse(rx_rd);

    // R5: early phase presents first bit while the clock is still idle
    set_cfg(5'b01000);
    tx_data = 8'h80;
    pulse(tx_wr);
    wait_clk(2);
    chk("R5 idle early bit", sdo, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule